// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block steps a processor bus through one transfer at a time on a bus whose low lines carry first the address and then the data. A transfer request (a 3-bit cycle code, an address, an upper-byte flag and write data) is taken when the sequencer is idle or in the last state of the previous cycle. The cycle then runs T1, T2, T3, zero or more wait states Tw, and T4. Each state lasts one clock.

During T1 the block pulses the address latch enable and drives the address. It then asserts the strobe that matches the cycle code: read, write or interrupt acknowledge. It holds memory-versus-I/O, the data direction and the transceiver enable for the right states, and it shows a 3-bit status code that goes passive when the transfer completes. The ready input decides how many wait states are added. For read-type cycles the data is captured from the bus on the edge that ends the last ready-sampling state.

Another bus master can ask for the bus with a hold request. The request is honoured only between cycles. The sequencer then raises its acknowledge and floats every line it drives until the request drops.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the sequencer is idle: ale_o low, rd_n_o, wr_n_o and inta_n_o high, den_n_o high, status_o = 3'b111, hlda_o low, bus_oe_o high, ad_oe_o low.
- R2: ale_o is high only in T1. In T1, ad_o carries addr bits [15:0], addr_hi_o carries addr bits [19:16] and ad_oe_o is high.
- R3: Cycle codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read and 110 memory write. In T2, T3 and every Tw, rd_n_o is low for codes 001/100/101, wr_n_o is low for 010/110 and inta_n_o is low for 000. Halt asserts no strobe, and at most one strobe is low at a time.
- R4: ready_i is sampled in T3 and in each Tw. One Tw follows for each sampled low, and T4 follows the first state that samples it high. Strobes stay active through every Tw.
- R5: Throughout a cycle mio_o equals code bit 2 (high for memory codes, low for I/O, acknowledge and halt). bhe_n_o is the inverse of the upper-byte request. The lane pair {bhe_n_o, ad_o[0] in T1} reads 00 whole word at even address, 01 upper byte at odd address, 10 lower byte at even address.
- R6: For write codes, ad_o carries the write data with ad_oe_o high from T2 to T4. For read-type codes (000/001/100/101), ad_oe_o is low from T2 to T4. ad_i is captured when the last ready sample is taken, and it is shown on rdata_o with rdata_vld_o high in T4 only.
- R7: status_o shows the cycle code in T1 and T2. In T3 and Tw it shows the code while ready_i is low and 111 once ready_i is high. In T4 it shows the code of a request being taken, or else 111. It is 111 when idle.
- R8: A hold request is granted only from idle or at the end of T4, with priority over a transfer request. While it is granted, hlda_o is high and bus_oe_o and ad_oe_o are low. When hold_i drops, the sequencer returns to idle.
- R9: dtr_o is high across T1 to T4 of a write cycle and low otherwise. den_n_o is low from T2 to T4 for writes, from T3 to T4 for read-type cycles, and never for halt.
- R10: accept_o is high exactly in the cycle a request is taken. A request taken in T4 starts its T1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one T state per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| code_i | input | 3 | Cycle code of the request |
| addr_i | input | 20 | Transfer address |
| byte_hi_i | input | 1 | Upper byte lane requested |
| wdata_i | input | 16 | Write data |
| ready_i | input | 1 | Transfer complete from the addressed device |
| hold_i | input | 1 | Bus request from another master |
| ad_i | input | 16 | Shared lines as seen from the bus (read data) |
| accept_o | output | 1 | Request taken this cycle |
| ad_o | output | 16 | Shared lines: address in T1, write data later |
| ad_oe_o | output | 1 | Drive enable for shared lines |
| addr_hi_o | output | 4 | Upper address bits in T1 |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| inta_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| mio_o | output | 1 | High for memory, low for I/O |
| bhe_n_o | output | 1 | Upper byte enable, active low |
| dtr_o | output | 1 | Data direction, high for transmit |
| den_n_o | output | 1 | Transceiver enable, active low |
| status_o | output | 3 | Cycle status code |
| hlda_o | output | 1 | Hold acknowledge |
| bus_oe_o | output | 1 | Drive enable for control and address lines |
| rdata_o | output | 16 | Captured read data |
| rdata_vld_o | output | 1 | Read data valid in T4 |

## Verification
The bench sweeps every cycle code against zero, one and two wait states and all three lane patterns. It checks each T state, so a strobe window that is one state short or long is caught. The same holds for a transceiver enable that opens in T2 for a read, or a status that goes passive before ready rises. A sequencer that counts waits wrong ends the strobe early, or flags read data outside T4. Hold is raised at the same time as a request and also in the middle of a cycle. A design that grants hold inside a cycle would drop the strobes before T4, and one that lets a request win over hold would start T1 with the bus released. A back-to-back pair checks that the T4 status already shows the next code and that T1 follows with no idle state between.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_HOLD
  } bus_st_e;

  localparam logic [2:0] CODE_INTA    = 3'b000;
  localparam logic [2:0] CODE_IO_RD   = 3'b001;
  localparam logic [2:0] CODE_IO_WR   = 3'b010;
  localparam logic [2:0] CODE_HALT    = 3'b011;
  localparam logic [2:0] CODE_FETCH   = 3'b100;
  localparam logic [2:0] CODE_MEM_RD  = 3'b101;
  localparam logic [2:0] CODE_MEM_WR  = 3'b110;
  localparam logic [2:0] CODE_PASSIVE = 3'b111;
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    hold_i,
  input  logic    ready_i,
  output bus_st_e st_o,
  output logic    take_o
);
  bus_st_e st_q, st_d;

  wire boundary = (st_q == ST_IDLE) || (st_q == ST_T4);
  assign take_o = boundary && req_i && !hold_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_T4: st_d = hold_i ? ST_HOLD : (req_i ? ST_T1 : ST_IDLE);
      ST_T1:          st_d = ST_T2;
      ST_T2:          st_d = ST_T3;
      ST_T3, ST_TW:   st_d = ready_i ? ST_T4 : ST_TW;
      ST_HOLD:        st_d = hold_i ? ST_HOLD : ST_IDLE;
      default:        st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assign st_o = st_q;

  assert_t4_after_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T4) |-> $past((st_q == ST_T3 || st_q == ST_TW) && ready_i));
  assert_wait_on_low_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TW) |-> $past(!ready_i));
  assert_t2_after_t1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T2) |-> $past(st_q == ST_T1));
endmodule

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
(
  input  logic [2:0] code_i,
  output logic       is_rd_o,
  output logic       is_wr_o,
  output logic       is_inta_o,
  output logic       is_mem_o
);
  always_comb begin
    is_rd_o   = 1'b0;
    is_wr_o   = 1'b0;
    is_inta_o = 1'b0;
    unique case (code_i)
      CODE_INTA:                         is_inta_o = 1'b1;
      CODE_IO_RD, CODE_FETCH, CODE_MEM_RD: is_rd_o = 1'b1;
      CODE_IO_WR, CODE_MEM_WR:           is_wr_o   = 1'b1;
      default: ;
    endcase
  end
  assign is_mem_o = code_i[2];
endmodule

// File: rtl/bcs_req_reg.sv
module bcs_req_reg #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [2:0]    code_i,
  input  logic [AW-1:0] addr_i,
  input  logic          byte_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [2:0]    code_o,
  output logic [AW-1:0] addr_o,
  output logic          byte_hi_o,
  output logic [DW-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_o    <= 3'b111;
      addr_o    <= '0;
      byte_hi_o <= 1'b0;
      wdata_o   <= '0;
    end else if (take_i) begin
      code_o    <= code_i;
      addr_o    <= addr_i;
      byte_hi_o <= byte_hi_i;
      wdata_o   <= wdata_i;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [2:0]    code_i,
  input  logic [AW-1:0] addr_i,
  input  logic          byte_hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ready_i,
  input  logic          hold_i,
  input  logic [DW-1:0] ad_i,
  output logic          accept_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          inta_n_o,
  output logic          mio_o,
  output logic          bhe_n_o,
  output logic          dtr_o,
  output logic          den_n_o,
  output logic [2:0]    status_o,
  output logic          hlda_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_vld_o
);
  localparam int HW = AW - DW;

  bus_st_e       st;
  logic          take;
  logic [2:0]    cur_code;
  logic [AW-1:0] cur_addr;
  logic          cur_hi;
  logic [DW-1:0] cur_wdata;
  logic          is_rd, is_wr, is_inta, is_mem;

  bcs_fsm u_fsm (
    .clk_i, .rst_ni, .req_i, .hold_i, .ready_i,
    .st_o(st), .take_o(take)
  );

  bcs_req_reg #(.AW(AW), .DW(DW)) u_req (
    .clk_i, .rst_ni, .take_i(take),
    .code_i, .addr_i, .byte_hi_i, .wdata_i,
    .code_o(cur_code), .addr_o(cur_addr), .byte_hi_o(cur_hi), .wdata_o(cur_wdata)
  );

  bcs_decode u_dec (
    .code_i(cur_code), .is_rd_o(is_rd), .is_wr_o(is_wr),
    .is_inta_o(is_inta), .is_mem_o(is_mem)
  );

  wire in_cyc  = st inside {ST_T1, ST_T2, ST_T3, ST_TW, ST_T4};
  wire data_ph = st inside {ST_T2, ST_T3, ST_TW, ST_T4};
  wire strb_ph = st inside {ST_T2, ST_T3, ST_TW};
  wire rd_ph   = st inside {ST_T3, ST_TW, ST_T4};
  wire rd_like = is_rd | is_inta;
  wire wr_dat  = data_ph & is_wr;

  assign accept_o  = take;
  assign ale_o     = (st == ST_T1);
  assign ad_oe_o   = ale_o | wr_dat;
  assign ad_o      = ale_o ? cur_addr[DW-1:0] : (wr_dat ? cur_wdata : '0);
  assign addr_hi_o = ale_o ? cur_addr[AW-1:DW] : {HW{1'b0}};
  assign rd_n_o    = ~(strb_ph & is_rd);
  assign wr_n_o    = ~(strb_ph & is_wr);
  assign inta_n_o  = ~(strb_ph & is_inta);
  assign mio_o     = in_cyc & is_mem;
  assign bhe_n_o   = in_cyc ? ~cur_hi : 1'b1;
  assign dtr_o     = in_cyc & is_wr;
  assign den_n_o   = ~(wr_dat | (rd_ph & rd_like));
  assign hlda_o    = (st == ST_HOLD);
  assign bus_oe_o  = ~hlda_o;

  always_comb begin
    unique case (st)
      ST_T1, ST_T2: status_o = cur_code;
      ST_T3, ST_TW: status_o = ready_i ? CODE_PASSIVE : cur_code;
      ST_T4:        status_o = take ? code_i : CODE_PASSIVE;
      default:      status_o = CODE_PASSIVE;
    endcase
  end

  // capture on the edge that leaves the last ready-sampling state
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_o <= '0;
    else if ((st == ST_T3 || st == ST_TW) && ready_i && rd_like) rdata_o <= ad_i;

  assign rdata_vld_o = (st == ST_T4) & rd_like;

  assert_one_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~rd_n_o, ~wr_n_o, ~inta_n_o}));
  assert_passive_before_t4_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_T4) |-> $past(status_o == CODE_PASSIVE));
  assert_hold_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(st == ST_T4 || st == ST_IDLE));
  assert_float_in_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !bus_oe_o && rd_n_o && wr_n_o));
  assert_rdata_after_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |-> $past(ready_i));
  assert_t1_after_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> $past(accept_o));
endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, byte_hi = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [2:0]  code = 3'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0, ad_in = '0;
  logic        accept, ad_oe, ale, rd_n, wr_n, inta_n, mio, bhe_n, dtr, den_n, hlda, bus_oe, rvld;
  logic [15:0] ad_out, rdata;
  logic [3:0]  addr_hi;
  logic [2:0]  status;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .code_i(code), .addr_i(addr),
    .byte_hi_i(byte_hi), .wdata_i(wdata), .ready_i(ready), .hold_i(hold), .ad_i(ad_in),
    .accept_o(accept), .ad_o(ad_out), .ad_oe_o(ad_oe), .addr_hi_o(addr_hi), .ale_o(ale),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .inta_n_o(inta_n), .mio_o(mio), .bhe_n_o(bhe_n),
    .dtr_o(dtr), .den_n_o(den_n), .status_o(status), .hlda_o(hlda), .bus_oe_o(bus_oe),
    .rdata_o(rdata), .rdata_vld_o(rvld)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic bit f_rd(input logic [2:0] c); return c == 3'd1 || c == 3'd4 || c == 3'd5; endfunction
  function automatic bit f_wr(input logic [2:0] c); return c == 3'd2 || c == 3'd6; endfunction

  task automatic strobes(input logic [2:0] c, input bit on, input string tag);
    chk(rd_n,   !(on && f_rd(c)),   {tag, " R3 rd_n"});
    chk(wr_n,   !(on && f_wr(c)),   {tag, " R3 wr_n"});
    chk(inta_n, !(on && c == 3'd0), {tag, " R3 inta_n"});
  endtask

  // Entered just after a negedge with the sequencer idle; leaves it idle.
  task automatic run_cycle(input logic [2:0] c, input int waits, input bit hi,
                           input logic [19:0] a, input logic [15:0] wd, input logic [15:0] rv);
    bit rl = f_rd(c) || c == 3'd0;
    bit wr = f_wr(c);
    req = 1; code = c; addr = a; byte_hi = hi; wdata = wd; #1;
    chk(accept, 1, "R10 accept in idle");
    chk(status, 3'h7, "R7 idle status");
    step(); req = 0; #1;                                          // T1
    chk(ale, 1, "R2 ale in T1");
    chk(ad_out, a[15:0], "R2 low address in T1");
    chk(addr_hi, a[19:16], "R2 high address in T1");
    chk(ad_oe, 1, "R2 ad_oe in T1");
    chk({bhe_n, ad_out[0]}, {!hi, a[0]}, "R5 byte lanes");
    chk(mio, c[2], "R5 mio");
    chk(status, c, "R7 T1 status");
    chk(dtr, wr, "R9 dtr T1");
    chk(den_n, 1, "R9 den off T1");
    strobes(c, 0, "T1");
    step(); ready = (waits == 0); ad_in = rv; #1;                 // T2
    chk(ale, 0, "R2 ale T2");
    strobes(c, 1, "T2");
    chk(status, c, "R7 T2 status");
    chk(den_n, !wr, "R9 den T2");
    chk(ad_oe, wr, "R6 ad_oe T2");
    if (wr) chk(ad_out, wd, "R6 write data T2");
    chk(mio, c[2], "R5 mio T2");
    step(); #1;                                                   // T3
    strobes(c, 1, "T3");
    chk(status, (waits == 0) ? 3'h7 : c, "R7 T3 status");
    chk(den_n, !(wr || rl), "R9 den T3");
    chk(rvld, 0, "R6 no valid in T3");
    for (int k = 1; k <= waits; k++) begin
      step(); ready = (k == waits); #1;                           // Tw
      strobes(c, 1, "R4 Tw");
      chk(status, (k == waits) ? 3'h7 : c, "R7 Tw status");
      chk(rvld, 0, "R4 no valid in Tw");
      chk(ale, 0, "R4 ale in Tw");
    end
    step(); ready = 0; ad_in = ~rv; #1;                           // T4
    strobes(c, 0, "R4 T4");
    chk(rvld, rl, "R6 valid in T4");
    if (rl) chk(rdata, rv, "R6 captured data");
    chk(den_n, !(wr || rl), "R9 den T4");
    chk(dtr, wr, "R9 dtr T4");
    chk(ad_oe, wr, "R6 ad_oe T4");
    chk(status, 3'h7, "R7 T4 status no request");
    step(); ready = 1; #1;                                        // idle
    chk(ale, 0, "R2 idle ale");
    chk(den_n, 1, "R9 idle den");
    chk(dtr, 0, "R9 idle dtr");
    chk(rvld, 0, "R6 idle valid");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    #1;
    chk(ale, 0, "R1 ale"); chk({rd_n, wr_n, inta_n}, 3'b111, "R1 strobes");
    chk(den_n, 1, "R1 den"); chk(status, 3'h7, "R1 status");
    chk(hlda, 0, "R1 hlda"); chk(bus_oe, 1, "R1 bus_oe"); chk(ad_oe, 0, "R1 ad_oe");
    step(); rst_n = 1; step();
    chk(accept, 0, "R10 no accept without request");

    for (int c = 0; c < 7; c++)
      for (int w = 0; w < 3; w++)
        for (int l = 0; l < 3; l++) begin
          bit hi = (l != 2);
          logic [19:0] a = 20'h9A000 + 20'(c * 64 + w * 8) * 2 + ((l == 1) ? 20'd1 : 20'd0);
          run_cycle(3'(c), w, hi, a, 16'(16'h1234 + c * 17 + w), 16'(16'hBEE0 + c * 3 + l));
        end

    // back-to-back: request taken in T4
    req = 1; code = 3'd6; addr = 20'h12340; byte_hi = 1; wdata = 16'hCAFE; #1;
    step(); req = 0; step(); ready = 1; step();
    req = 1; code = 3'd5; addr = 20'h56782; #1;
    step(); #1;                                                   // T4
    chk(accept, 1, "R10 accept in T4");
    chk(status, 3'd5, "R7 T4 shows next code");
    step(); req = 0; #1;                                          // T1 of second
    chk(ale, 1, "R10 T1 right after T4");
    chk(ad_out, 16'h6782, "R10 second address");
    chk(status, 3'd5, "R7 second T1 status");
    repeat (4) step();                                            // T2,T3,T4,idle
    #1; chk(ale, 0, "R10 back to idle");

    // hold and request together in idle
    hold = 1; req = 1; code = 3'd4; addr = 20'h00100; #1;
    chk(accept, 0, "R8 hold beats request");
    step(); #1;
    chk(hlda, 1, "R8 hlda granted from idle");
    chk(bus_oe, 0, "R8 bus floated");
    chk(ad_oe, 0, "R8 ad floated");
    chk(ale, 0, "R8 no T1 in hold");
    step(); #1; chk(hlda, 1, "R8 hold kept");
    chk(accept, 0, "R8 no accept in hold");
    hold = 0; step(); #1;
    chk(hlda, 0, "R8 released to idle");
    chk(bus_oe, 1, "R8 bus driven again");
    chk(accept, 1, "R10 accept after release");
    step(); req = 0; #1; chk(ale, 1, "R8 T1 after hold");
    step(); hold = 1; #1;                                         // T2
    chk(hlda, 0, "R8 no grant in T2");
    step(); #1; chk(hlda, 0, "R8 no grant in T3");
    chk(rd_n, 0, "R8 strobe kept in T3");
    step(); #1; chk(hlda, 0, "R8 no grant in T4");
    step(); #1; chk(hlda, 1, "R8 grant after T4");
    chk(ad_oe, 0, "R8 ad floated after T4");
    hold = 0; step(); #1; chk(hlda, 0, "R8 release");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule